// File: doc/BRIEF.md
# Early-Output Dual-Rail Two-Input Logic Gate

This block is a purely combinational two-input gate for delay-insensitive, four-phase dual-rail datapaths. Each signal travels on two wires: a true rail and a false rail. With both rails low the signal is NULL (no data). With only the false rail high it carries logic 0. With only the true rail high it carries logic 1. Unlike a gate that waits for every operand, this gate drives a result as soon as the operands present are enough to fix it. The core computes OR. The true output rail rises the moment either operand carries 1. The false output rail rises only once both operands carry 0, which is the one input state the early set leaves uncovered.

Three static parameters select rail swaps on operand A, operand B and the result. A rail swap is the only means of inversion, so the same core realises OR, NOR, AND, NAND and the forms with one inverted operand. A per-signal validity flag, formed from the signal's two rails, is brought out for each operand and for the result. A surrounding completion stage uses these flags to learn which operands have actually arrived, because a valid result does not imply that both operands are present. The gate holds no state: its outputs follow its inputs, and the result falls back to NULL once the operand state that produced it is withdrawn.

Top module: `eo_gate`

## Requirements
- R1: When both operands are NULL (both rails of each low), both result rails are low.
- R2: In the default OR form (no swaps), the result is logic 1 (true rail high, false rail low) as soon as either operand is logic 1, whether the other operand is NULL, 0 or 1.
- R3: In the default OR form, the result is logic 0 (false rail high, true rail low) only when both operands are valid and both are 0.
- R4: If only one operand is valid and its value cannot decide the result on its own (0 for OR, 1 for AND), the result stays NULL.
- R5: Setting INV_A or INV_B to 1 inverts that operand only by exchanging its true and false rails. For example, with INV_A=1 alone the gate computes (not A) or B, and an A of 0 forces an early 1.
- R6: Setting INV_Y to 1 exchanges the result rails. With INV_A=INV_B=INV_Y=1 the gate is AND: the result is 0 as soon as either operand is 0 and 1 only when both are 1. With INV_A=INV_B=1 and INV_Y=0 it is NAND.
- R7: a_vld equals a_t OR a_f, b_vld equals b_t OR b_f, and y_vld equals y_t OR y_f, at all times.
- R8: For legal operands (never both rails of one operand high), the two result rails are never high together.
- R9: The result has no memory. After any sequence of operand states, it depends only on the present operands. Returning both operands to NULL returns the result to NULL without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_t | input | 1 | Operand A true rail |
| a_f | input | 1 | Operand A false rail |
| b_t | input | 1 | Operand B true rail |
| b_f | input | 1 | Operand B false rail |
| y_t | output | 1 | Result true rail |
| y_f | output | 1 | Result false rail |
| a_vld | output | 1 | Operand A carries data (either rail high) |
| b_vld | output | 1 | Operand B carries data (either rail high) |
| y_vld | output | 1 | Result carries data (either rail high) |

## Verification
The bench drives all nine operand-state pairs through four rail-swap configurations (OR, AND, NAND, and OR with A inverted) and compares each result with a three-valued behavioural model. The key corner case is the half-arrived operand pair. A gate that waited for both operands would miss the early 1 when one side is still NULL. A gate that raised the false rail too soon would signal 0 with only one operand present. Sequences that move the operands up and back down check that no result is latched: a stateful gate would hold its previous output after the operands returned to NULL. Swapping the wrong rail in any configuration shows up as an inverted or early result in the model comparison.

// File: rtl/eo_gate_pkg.sv
package eo_gate_pkg;

  // One dual-rail wire pair: t high = logic 1, f high = logic 0, both low = NULL.
  typedef struct packed {
    logic t;
    logic f;
  } dr_t;

  localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/eo_rail_swap.sv
module eo_rail_swap
  import eo_gate_pkg::*;
#(
  parameter bit SWAP = 1'b0
) (
  input  dr_t din,
  output dr_t dout
);

  generate
    if (SWAP) begin : g_swap
      // Inversion of a dual-rail signal is just a wire exchange.
      assign dout.t = din.f;
      assign dout.f = din.t;
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate

endmodule

// File: rtl/eo_valid_det.sv
module eo_valid_det
  import eo_gate_pkg::*;
#(
  parameter int unsigned N = 1
) (
  input  dr_t [N-1:0]  sig,
  output logic [N-1:0] vld
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign vld[i] = sig[i].t | sig[i].f;
    end
  endgenerate

endmodule

// File: rtl/eo_or_core.sv
module eo_or_core
  import eo_gate_pkg::*;
(
  input  dr_t p,
  input  dr_t q,
  output dr_t r
);

  logic early_one;
  logic full_zero;

  // Early set: a single 1 on either side decides the OR.
  always_comb begin
    early_one = p.t | q.t;
  end

  // Remaining case: both sides present and both 0.
  always_comb begin
    full_zero = p.f & q.f;
  end

  assign r.t = early_one;
  assign r.f = full_zero;

endmodule

// File: rtl/eo_gate.sv
module eo_gate
  import eo_gate_pkg::*;
#(
  parameter bit INV_A = 1'b0,
  parameter bit INV_B = 1'b0,
  parameter bit INV_Y = 1'b0
) (
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  output logic y_t,
  output logic y_f,
  output logic a_vld,
  output logic b_vld,
  output logic y_vld
);

  localparam int unsigned NVLD = NUM_OPS + 1;

  dr_t op_a, op_b;
  dr_t core_a, core_b;
  dr_t core_y, res_y;
  dr_t [NVLD-1:0] vld_in;
  logic [NVLD-1:0] vld_out;

  assign op_a = '{t: a_t, f: a_f};
  assign op_b = '{t: b_t, f: b_f};

  eo_rail_swap #(.SWAP(INV_A)) u_swap_a (.din(op_a),   .dout(core_a));
  eo_rail_swap #(.SWAP(INV_B)) u_swap_b (.din(op_b),   .dout(core_b));

  eo_or_core u_core (.p(core_a), .q(core_b), .r(core_y));

  eo_rail_swap #(.SWAP(INV_Y)) u_swap_y (.din(core_y), .dout(res_y));

  assign y_t = res_y.t;
  assign y_f = res_y.f;

  assign vld_in[0] = op_a;
  assign vld_in[1] = op_b;
  assign vld_in[2] = res_y;

  eo_valid_det #(.N(NVLD)) u_vld (.sig(vld_in), .vld(vld_out));

  assign a_vld = vld_out[0];
  assign b_vld = vld_out[1];
  assign y_vld = vld_out[2];

endmodule

// File: rtl/eo_gate_chk.sv
module eo_gate_chk #(
  parameter bit INV_A = 1'b0,
  parameter bit INV_B = 1'b0,
  parameter bit INV_Y = 1'b0
) (
  input logic a_t,
  input logic a_f,
  input logic b_t,
  input logic b_f,
  input logic y_t,
  input logic y_f,
  input logic a_vld,
  input logic b_vld,
  input logic y_vld
);

  logic legal;
  logic a_weak;
  assign legal  = !(a_t && a_f) && !(b_t && b_f);
  // Operand A present with the value that cannot decide the result alone.
  assign a_weak = INV_A ? a_t : a_f;

  always_comb begin
    // R1
    null_in_null_out_chk: assert (!(!a_t && !a_f && !b_t && !b_f) || (!y_t && !y_f))
      else $error("null operands produced a result");
    // R8
    no_double_rail_chk: assert (!legal || !(y_t && y_f))
      else $error("both result rails high");
    // R2
    result_needs_operand_chk: assert (!y_vld || a_vld || b_vld)
      else $error("result valid with no operand");
    // R3
    full_set_completes_chk: assert (!legal || !(a_vld && b_vld) || y_vld)
      else $error("both operands valid but result NULL");
    // R4
    no_early_weak_chk: assert (!legal || !(a_vld && !b_vld && a_weak) || !y_vld)
      else $error("non-deciding operand alone produced a result");
  end

endmodule

bind eo_gate eo_gate_chk #(.INV_A(INV_A), .INV_B(INV_B), .INV_Y(INV_Y)) u_chk (
  .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
  .y_t(y_t), .y_f(y_f), .a_vld(a_vld), .b_vld(b_vld), .y_vld(y_vld)
);

// File: tb/eo_gate_tb.sv
module eo_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 4;
  // states: 0 = NULL, 1 = logic 0, 2 = logic 1
  localparam bit [NDUT-1:0] IA = 4'b0111;
  localparam bit [NDUT-1:0] IB = 4'b0011;
  localparam bit [NDUT-1:0] IY = 4'b0001;

  logic clk;
  logic rst_n;
  logic a_t, a_f, b_t, b_f;
  logic [NDUT-1:0] y_t, y_f, a_v, b_v, y_v;
  int checks = 0;
  int errors = 0;
  int cur_a = 0;
  int cur_b = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // index 0: AND, 1: NAND, 2: OR with A inverted, 3: plain OR
  eo_gate #(.INV_A(1'b1), .INV_B(1'b1), .INV_Y(1'b1)) u_dut_and (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(y_t[0]), .y_f(y_f[0]),
    .a_vld(a_v[0]), .b_vld(b_v[0]), .y_vld(y_v[0]));
  eo_gate #(.INV_A(1'b1), .INV_B(1'b1), .INV_Y(1'b0)) u_dut_nand (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(y_t[1]), .y_f(y_f[1]),
    .a_vld(a_v[1]), .b_vld(b_v[1]), .y_vld(y_v[1]));
  eo_gate #(.INV_A(1'b1), .INV_B(1'b0), .INV_Y(1'b0)) u_dut_imp (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(y_t[2]), .y_f(y_f[2]),
    .a_vld(a_v[2]), .b_vld(b_v[2]), .y_vld(y_v[2]));
  eo_gate u_dut (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(y_t[3]), .y_f(y_f[3]),
    .a_vld(a_v[3]), .b_vld(b_v[3]), .y_vld(y_v[3]));

  function automatic int flip(int v, bit inv);
    if (v == 0 || !inv) return v;
    return 3 - v;
  endfunction

  function automatic int model(int a, int b, bit ia, bit ib, bit iy);
    int pa = flip(a, ia);
    int pb = flip(b, ib);
    int r;
    if (pa == 2 || pb == 2) r = 2;
    else if (pa == 1 && pb == 1) r = 1;
    else r = 0;
    return flip(r, iy);
  endfunction

  function automatic string tag_for(int d, int a, int b, int exp);
    if (a == 0 && b == 0) return "R1";
    if (exp == 0) return "R4";
    if (d == 3) return (exp == 2) ? "R2" : "R3";
    if (d == 2) return "R5";
    return "R6";
  endfunction

  task automatic apply(int a, int b);
    @(posedge clk);
    a_t = (a == 2); a_f = (a == 1);
    b_t = (b == 2); b_f = (b == 1);
    cur_a = a; cur_b = b;
  endtask

  task automatic compare(string ovr);
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      int exp = model(cur_a, cur_b, IA[d], IB[d], IY[d]);
      int got = (y_t[d] && y_f[d]) ? 3 : (y_t[d] ? 2 : (y_f[d] ? 1 : 0));
      string tg = (ovr != "") ? ovr : tag_for(d, cur_a, cur_b, exp);
      checks++;
      if (got != exp) begin
        errors++;
        $display("FAIL %s dut%0d a=%0d b=%0d result actual=%0d expected=%0d",
                 tg, d, cur_a, cur_b, got, exp);
      end
      checks++;
      if (got == 3) begin
        errors++;
        $display("FAIL R8 dut%0d both result rails high actual=3 expected=%0d", d, exp);
      end
      checks++;
      if (a_v[d] != (cur_a != 0) || b_v[d] != (cur_b != 0) || y_v[d] != (exp != 0)) begin
        errors++;
        $display("FAIL R7 dut%0d valid actual=%b%b%b expected=%b%b%b", d,
                 a_v[d], b_v[d], y_v[d], cur_a != 0, cur_b != 0, exp != 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    a_t = 0; a_f = 0; b_t = 0; b_f = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    compare("R1");  // reset state: all NULL
    rst_n = 1;
    // full sweep of the nine operand-state pairs, all configurations
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        apply(a, b);
        compare("");
      end
    end
    // R9: arrival order and withdrawal, no memory
    apply(0, 0); compare("R9");
    apply(0, 2); compare("");      // early 1 with A still NULL
    apply(1, 2); compare("");
    apply(1, 0); compare("R9");    // B withdrawn, prior 1 must not persist
    apply(0, 0); compare("R9");
    apply(1, 0); compare("");
    apply(1, 1); compare("");
    apply(0, 1); compare("R9");
    apply(2, 1); compare("");
    apply(2, 0); compare("R9");
    apply(0, 0); compare("R9");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule